// File: doc/BRIEF.md
# Reset Exception Sequencer

This block is the reset front end of a small 16-bit processor with a 24-bit address space. It watches an active-low external reset pin and a one-cycle watchdog overflow pulse. Once either source is accepted, it holds the core and every on-chip peripheral in reset. When the reset is released, it runs the reset exception. The exception reads a four-byte start vector from the bottom of memory over a byte-wide request/valid read port. It keeps the interrupt mask bit raised for the whole sequence. At the end it hands the core a 24-bit start program counter together with a one-cycle start strobe.

The pin first passes through a two-flop synchronizer. A low level on the pin counts as a reset during operation only when it lasts at least a minimum number of clocks; shorter glitches change nothing. A qualified pin reset or a watchdog pulse always wins over any sequence already under way. It aborts that sequence and starts the vector fetch again from the first byte. A separate synchronous active-high `rst` input initializes the block itself at power-up and leaves it in the held state.

Top module: `rsx_reset_seq`

## Requirements
- R1: After `rst`, `sys_rst` and `imask_set` are 1, `rd_req` and `start_exec` are 0, and no fetch begins while the pin stays low.
- R2: A pin low on at least MIN_LOW (20) consecutive clock edges asserts `sys_rst` at the second edge after the 20th low sample has left the synchronizer (the 22nd edge after the pin falls) and aborts any fetch in progress.
- R3: A pin low on 19 or fewer consecutive edges has no effect: `sys_rst` stays as it was, and a fetch in progress keeps its address and completes.
- R4: The fetch starts on the rising pin, never while it is low: `rd_req` goes to 1 at the third clock edge after the pin rises.
- R5: A one-cycle `wdt_ovf` pulse, in any state, raises `sys_rst` with `rd_req` 0 at the next edge, and `rd_req` rises with `rd_addr` = 0 one edge later. A fetch that was in progress restarts from address 0.
- R6: Vector bytes are read at `rd_addr` 0, 1, 2, 3 in that order, one per cycle in which `rd_req` and `rd_valid` are both 1. While it waits for `rd_valid`, `rd_req` and `rd_addr` stay unchanged for any number of cycles.
- R7: The byte from address 0 is dropped. `start_pc` = {byte1, byte2, byte3}, with byte1 as the most significant byte. `start_exec` is 1 for exactly the cycle after the edge that captures byte 3, and `sys_rst` is 0 from that cycle on.
- R8: `imask_set` is 1 from reset acceptance through the `start_exec` cycle and 0 afterwards.
- R9: After `start_exec`, the block stays idle with `rd_req`, `start_exec` and `sys_rst` at 0, and it ignores `rd_valid` until the next accepted reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block initialization |
| res_n_pin | input | 1 | Asynchronous active-low external reset pin |
| wdt_ovf | input | 1 | One-cycle watchdog overflow pulse |
| rd_req | output | 1 | Vector byte read request |
| rd_addr | output | 24 | Byte address of the pending read |
| rd_data | input | 8 | Read data, valid when rd_valid is 1 |
| rd_valid | input | 1 | Read data valid, completes the pending read |
| sys_rst | output | 1 | Reset to the core state and peripheral registers |
| imask_set | output | 1 | Forces the interrupt mask bit to 1 |
| start_exec | output | 1 | One-cycle strobe: begin execution at start_pc |
| start_pc | output | 24 | Start program counter taken from the vector |

## Verification
The pin path has two synchronizer flops and a state register. The request therefore rises at the third edge after the pin rises, and an accepted long pulse shows up on `sys_rst` exactly at the 22nd edge after the pin falls. A watchdog pulse acts one edge later and restarts the request one edge after that. The 4th accepted byte produces `start_exec` in the cycle after its edge, and the following cycle returns the block to idle. Inputs are driven on the falling clock edge and results are sampled on later falling edges counted to those exact edges. Every wait for `rd_valid` is checked on each cycle for a held address.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_FETCH = 2'd2,
    ST_START = 2'd3
  } rsx_state_e;
endpackage

// File: rtl/rsx_sync.sv
module rsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsx_width_qual.sv
module rsx_width_qual #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic qualified
);
  localparam int CW = $clog2(MIN_LOW);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || pin_s)        low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign qualified = !pin_s && (low_cnt == SAT);

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pin_s |=> (low_cnt == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= SAT); // R2
endmodule

// File: rtl/rsx_vec_fetch.sv
module rsx_vec_fetch #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int VEC_BYTES = 4,
  parameter int VEC_BASE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic [ADDR_W-1:0] vec_word
);
  localparam int IW = $clog2(VEC_BYTES);
  localparam int SW = ADDR_W - DATA_W;
  localparam logic [IW-1:0] LAST = IW'(VEC_BYTES - 1);

  logic [IW-1:0] idx;
  logic [SW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || !en)    idx <= '0;
    else if (rd_valid) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 shreg <= '0;
    else if (en && rd_valid) shreg <= vec_word[SW-1:0];
  end

  assign vec_word = {shreg, rd_data};
  assign rd_req   = en;
  assign rd_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(idx);
  assign done     = en && rd_valid && (idx == LAST);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (!rd_req || $stable(rd_addr))); // R6
endmodule

// File: rtl/rsx_reset_seq.sv
module rsx_reset_seq #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int VEC_BYTES   = 4,
  parameter int VEC_BASE    = 0,
  parameter int MIN_LOW     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_n_pin,
  input  logic              wdt_ovf,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              sys_rst,
  output logic              imask_set,
  output logic              start_exec,
  output logic [ADDR_W-1:0] start_pc
);
  import rsx_pkg::*;

  rsx_state_e        state, state_nxt;
  logic              pin_s, qualified, fetch_done, kill;
  logic [ADDR_W-1:0] vec_word;

  rsx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(res_n_pin), .q(pin_s)
  );

  rsx_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .pin_s(pin_s), .qualified(qualified)
  );

  rsx_vec_fetch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BYTES(VEC_BYTES), .VEC_BASE(VEC_BASE)
  ) u_fetch (
    .clk(clk), .rst(rst), .en(state == ST_FETCH),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .done(fetch_done), .vec_word(vec_word)
  );

  assign kill = qualified || wdt_ovf;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_HOLD:  if (pin_s) state_nxt = ST_FETCH;
      ST_FETCH: if (fetch_done) state_nxt = ST_START;
      ST_START: state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
    if (kill) state_nxt = ST_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HOLD;
    else     state <= state_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                                        start_pc <= '0;
    else if (state == ST_FETCH && fetch_done && !kill) start_pc <= vec_word;
  end

  assign sys_rst    = (state == ST_HOLD) || (state == ST_FETCH);
  assign imask_set  = (state != ST_IDLE);
  assign start_exec = (state == ST_START);

  AST_QUAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    qualified |=> (sys_rst && !rd_req)); // R2
  AST_WDT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf |=> (sys_rst && !rd_req)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_exec |=> !start_exec); // R7
  AST_START_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(start_exec) |-> ($past(rd_valid) && $past(rd_req))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !imask_set |-> (!rd_req && !sys_rst && !start_exec)); // R9
endmodule

// File: tb/rsx_reset_seq_tb.sv
module rsx_reset_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_n_pin = 1'b0;
  logic        wdt_ovf = 1'b0;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_valid = 1'b0;
  logic        sys_rst, imask_set, start_exec;
  logic [23:0] start_pc;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  rsx_reset_seq u_dut (
    .clk(clk), .rst(rst), .res_n_pin(res_n_pin), .wdt_ovf(wdt_ovf),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .sys_rst(sys_rst), .imask_set(imask_set), .start_exec(start_exec),
    .start_pc(start_pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge where a request for address a is expected.
  task automatic serve_byte(input logic [23:0] a, input int dly, input logic [7:0] d);
    check(rd_req === 1'b1, "R6 request present", 32'(rd_req), 1);
    check(rd_addr === a, "R6 byte address order", 32'(rd_addr), 32'(a));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check(rd_req === 1'b1 && rd_addr === a, "R6 address held while waiting",
            32'(rd_addr), 32'(a));
    end
    rd_valid = 1'b1;
    rd_data  = d;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic serve_vec(input logic [31:0] v, input logic [15:0] dl, input int first);
    for (int i = first; i < 4; i++)
      serve_byte(24'(i), int'(dl[4*i +: 4]), v[8*(3-i) +: 8]);
    check(start_exec === 1'b1, "R7 start strobe", 32'(start_exec), 1);
    check(start_pc === v[23:0], "R7 start pc", 32'(start_pc), 32'(v[23:0]));
    check(sys_rst === 1'b0, "R7 reset released", 32'(sys_rst), 0);
    check(imask_set === 1'b1, "R8 mask during start", 32'(imask_set), 1);
    @(negedge clk);
    check(start_exec === 1'b0, "R7 single-cycle strobe", 32'(start_exec), 0);
    check(imask_set === 1'b0, "R8 mask dropped after start", 32'(imask_set), 0);
    check(rd_req === 1'b0, "R9 no request after start", 32'(rd_req), 0);
  endtask

  task automatic wdt_pulse();
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
  endtask

  task automatic t_power_up();
    check(sys_rst === 1'b1 && imask_set === 1'b1, "R1 held after init",
          {30'd0, sys_rst, imask_set}, 3);
    check(rd_req === 1'b0 && start_exec === 1'b0, "R1 quiet after init",
          {30'd0, rd_req, start_exec}, 0);
    repeat (5) @(negedge clk);
    check(rd_req === 1'b0 && sys_rst === 1'b1, "R4 no fetch while pin low",
          {30'd0, rd_req, sys_rst}, 1);
    res_n_pin = 1'b1;
    @(negedge clk);
    check(rd_req === 1'b0, "R4 no request at edge 1", 32'(rd_req), 0);
    @(negedge clk);
    check(rd_req === 1'b0, "R4 no request at edge 2", 32'(rd_req), 0);
    @(negedge clk);
    check(rd_req === 1'b1, "R4 request at edge 3", 32'(rd_req), 1);
    serve_vec(32'hAA123456, 16'h5130, 0);
  endtask

  task automatic t_short_pulse();
    bit bad = 0;
    repeat (3) @(negedge clk);
    res_n_pin = 1'b0;
    repeat (19) begin
      @(negedge clk);
      if (sys_rst !== 1'b0) bad = 1;
    end
    res_n_pin = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (sys_rst !== 1'b0 || rd_req !== 1'b0) bad = 1;
    end
    check(!bad, "R3 19-cycle pulse ignored", 32'(bad), 0);
  endtask

  task automatic t_long_pulse();
    res_n_pin = 1'b0;
    for (int i = 1; i <= 22; i++) begin
      @(negedge clk);
      if (i == 21) check(sys_rst === 1'b0, "R2 not yet held at edge 21", 32'(sys_rst), 0);
      if (i == 22) check(sys_rst === 1'b1, "R2 held at edge 22", 32'(sys_rst), 1);
      if (i == 20) res_n_pin = 1'b1;
    end
    @(negedge clk);
    check(rd_req === 1'b1, "R4 fetch after long pulse", 32'(rd_req), 1);
    serve_vec(32'h00ABCDEF, 16'h0202, 0);
  endtask

  task automatic t_wdt();
    wdt_pulse();
    check(sys_rst === 1'b1 && rd_req === 1'b0, "R5 watchdog holds",
          {30'd0, sys_rst, rd_req}, 2);
    check(imask_set === 1'b1, "R8 mask on watchdog", 32'(imask_set), 1);
    @(negedge clk);
    check(rd_req === 1'b1 && rd_addr === 24'd0, "R5 fetch one edge later",
          {7'd0, rd_req, rd_addr}, 32'h0100_0000);
    serve_vec(32'h55FFEE01, 16'h1000, 0);
  endtask

  task automatic t_abort();
    wdt_pulse();
    @(negedge clk);
    serve_byte(24'd0, 2, 8'h11);
    serve_byte(24'd1, 0, 8'h22);
    wdt_pulse();
    check(rd_req === 1'b0 && sys_rst === 1'b1, "R5 abort mid fetch",
          {30'd0, rd_req, sys_rst}, 1);
    @(negedge clk);
    serve_vec(32'h99765432, 16'h0110, 0);
  endtask

  task automatic t_short_in_fetch();
    bit bad = 0;
    wdt_pulse();
    @(negedge clk);
    serve_byte(24'd0, 0, 8'hC3);
    res_n_pin = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (rd_req !== 1'b1 || rd_addr !== 24'd1) bad = 1;
    end
    res_n_pin = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (rd_req !== 1'b1 || rd_addr !== 24'd1) bad = 1;
    end
    check(!bad, "R3 short pulse leaves fetch alone", 32'(bad), 0);
    serve_vec(32'hC3012345, 16'h3000, 1);
  endtask

  task automatic t_idle();
    bit bad = 0;
    rd_valid = 1'b1;
    rd_data  = 8'h77;
    @(negedge clk);
    rd_valid = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (rd_req !== 1'b0 || start_exec !== 1'b0 || sys_rst !== 1'b0) bad = 1;
    end
    check(!bad, "R9 idle ignores read data", 32'(bad), 0);
    check(start_pc === 24'h012345, "R9 start pc kept", 32'(start_pc), 32'h012345);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_power_up();
    t_short_pulse();
    t_long_pulse();
    t_wdt();
    t_abort();
    t_short_in_fetch();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule